// File: doc/BRIEF.md
# Calendar Clock with Deferred Register Writes

This block keeps wall-clock time and calendar date, advancing by one second on each pulse of a one-second tick input. Seconds, minutes and hours roll over into the day, and days roll into the month using the real month lengths. February has 29 days when a software-owned leap flag is set and 28 days otherwise. Months roll into a six-bit year that counts from 2010, so the range runs from 2010 to 2073.

Software reaches the block over a small word-addressed register bus. Word 0 is a read-only control/status word, word 1 is the packed time and word 2 is the packed date. A write to the time or date word is not applied at once. The block captures the value, raises a busy flag for that word and commits the value a fixed number of clock cycles later. While its flag is high, further writes to that word are dropped. A driver writes a word, polls its busy flag until it clears, and only then writes that word again.

Top module: `calendar_clock`

## Requirements
- R1: After reset the time word reads 0 (00:00:00), the date word reads 0x00000101 (day 1, month 1, year offset 0, leap flag clear), and the control word reads 0.
- R2: Word address 1 is the time word: seconds in bits [5:0], minutes in [13:8], hours in [20:16], all other bits read 0 whatever was written.
- R3: Word address 2 is the date word: day of month in bits [4:0], month (1 to 12) in [11:8], year offset from 2010 in [21:16], leap flag in bit 22, all other bits read 0.
- R4: A write to the time word while it is idle sets control bit 8. The bit stays set for exactly COMMIT_CYCLES clock cycles, and the time word keeps its old contents until the edge on which the bit clears, when it takes the written value.
- R5: A write to the date word while it is idle sets control bit 7. The bit stays set for exactly COMMIT_CYCLES clock cycles, and the date word takes the written value on the edge on which the bit clears.
- R6: A write to the time or date word while that word's busy bit is set has no effect on the committed value.
- R7: On a tick, seconds advance. 59 seconds wraps to 0 and advances minutes, 59 minutes wraps to 0 and advances hours, and 23 hours wraps to 0 and advances the day.
- R8: A day advance past the month's last day (30 for months 4, 6, 9 and 11, 31 for the other non-February months) sets the day to 1 and advances the month.
- R9: February ends after day 29 when the leap flag is set and after day 28 when it is clear. The leap flag is never changed by counting.
- R10: An advance from month 12 sets the month to 1 and increments the year offset, and offset 63 wraps to 0.
- R11: A tick updates the time and date words on the same clock edge. Without a tick or a commit, neither word changes.
- R12: On the edge where a time commit happens, the committed value replaces the time word, and a coincident tick neither advances it nor carries into the date.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for counting and register access |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | 2 | Word address: 0 control, 1 time, 2 date |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The checker watches, on every cycle, that an idle write raises the right busy flag, that a flag falls only on its commit edge, that both words hold steady without a tick or commit, and that second wrap, February's non-leap end and December's year carry land on the next edge. The exact length of each busy window, the dropping of a second write, the masking of unused bits, the 30- and 31-day month ends, the leap-February path, the year-63 wrap and the commit winning over a coincident tick are shown only by the bench's scenarios. Those scenarios compare read-back words against values the bench works out from the requirements.

// File: rtl/calendar_clock.sv
module calendar_clock #(
  parameter int COMMIT_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int CW = $clog2(COMMIT_CYCLES + 1);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TIME = 2'd1;
  localparam logic [1:0] A_DATE = 2'd2;

  logic [5:0] sec, min;
  logic [4:0] hr, day;
  logic [3:0] mon;
  logic [5:0] yr;
  logic       leap;

  logic          t_busy, d_busy;
  logic [CW-1:0] t_cnt, d_cnt;
  logic [16:0]   t_pend;
  logic [15:0]   d_pend;
  logic          unused_wbits;

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic lp);
    case (m)
      4'd2:                       month_len = lp ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:    month_len = 5'd30;
      default:                    month_len = 5'd31;
    endcase
  endfunction

  wire wr_time  = bus_wr && bus_addr == A_TIME && !t_busy;
  wire wr_date  = bus_wr && bus_addr == A_DATE && !d_busy;
  wire t_commit = t_busy && t_cnt == CW'(1);
  wire d_commit = d_busy && d_cnt == CW'(1);

  wire sec_top  = sec == 6'd59;
  wire min_top  = min == 6'd59;
  wire hr_top   = hr == 5'd23;
  wire day_top  = day >= month_len(mon, leap);
  wire mon_top  = mon >= 4'd12;

  wire step_t   = tick && !t_commit;
  wire c_min    = step_t && sec_top;
  wire c_hr     = c_min && min_top;
  wire c_day    = c_hr && hr_top && !d_commit;
  wire c_mon    = c_day && day_top;
  wire c_yr     = c_mon && mon_top;

  assign unused_wbits = ^{bus_wdata[31:23], bus_wdata[15:14], bus_wdata[7:6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_busy <= 1'b0;
      t_cnt  <= '0;
      t_pend <= '0;
    end else if (wr_time) begin
      t_busy <= 1'b1;
      t_cnt  <= CW'(COMMIT_CYCLES);
      t_pend <= {bus_wdata[20:16], bus_wdata[13:8], bus_wdata[5:0]};
    end else if (t_busy) begin
      t_cnt <= t_cnt - CW'(1);
      if (t_commit) t_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_busy <= 1'b0;
      d_cnt  <= '0;
      d_pend <= '0;
    end else if (wr_date) begin
      d_busy <= 1'b1;
      d_cnt  <= CW'(COMMIT_CYCLES);
      d_pend <= {bus_wdata[22:16], bus_wdata[11:8], bus_wdata[4:0]};
    end else if (d_busy) begin
      d_cnt <= d_cnt - CW'(1);
      if (d_commit) d_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= '0;
      min <= '0;
      hr  <= '0;
    end else if (t_commit) begin
      {hr, min, sec} <= t_pend;
    end else if (step_t) begin
      sec <= sec_top ? 6'd0 : sec + 6'd1;
      if (c_min) min <= min_top ? 6'd0 : min + 6'd1;
      if (c_hr)  hr  <= hr_top ? 5'd0 : hr + 5'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day  <= 5'd1;
      mon  <= 4'd1;
      yr   <= '0;
      leap <= 1'b0;
    end else if (d_commit) begin
      {leap, yr, mon, day} <= d_pend;
    end else if (c_day) begin
      day <= day_top ? 5'd1 : day + 5'd1;
      if (c_mon) mon <= mon_top ? 4'd1 : mon + 4'd1;
      if (c_yr)  yr  <= yr + 6'd1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {23'b0, t_busy, d_busy, 7'b0};
      A_TIME:  bus_rdata = {11'b0, hr, 2'b0, min, 2'b0, sec};
      A_DATE:  bus_rdata = {9'b0, leap, yr, 4'b0, mon, 3'b0, day};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/calendar_clock_chk.sv
module calendar_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       t_busy,
  input logic       d_busy,
  input logic       t_commit,
  input logic       d_commit,
  input logic [5:0] sec,
  input logic [5:0] min,
  input logic [4:0] hr,
  input logic [4:0] day,
  input logic [3:0] mon,
  input logic [5:0] yr,
  input logic       leap
);
  p_time_busy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd1 && !t_busy |=> t_busy);

  p_time_busy_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    t_busy && !t_commit |=> t_busy);

  p_date_busy_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd2 && !d_busy |=> d_busy);

  p_date_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    d_busy && !d_commit |=> d_busy);

  p_sec_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !t_commit && sec == 6'd59 |=> sec == 6'd0);

  p_feb_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !t_commit && !d_commit && sec == 6'd59 && min == 6'd59 && hr == 5'd23
    && mon == 4'd2 && day == 5'd28 && !leap |=> mon == 4'd3 && day == 5'd1 && !leap);

  p_year_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !t_commit && !d_commit && sec == 6'd59 && min == 6'd59 && hr == 5'd23
    && mon == 4'd12 && day == 5'd31 |=> mon == 4'd1 && day == 5'd1 && yr == $past(yr) + 6'd1);

  p_time_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !t_commit |=> $stable({hr, min, sec}));

  p_date_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !d_commit |=> $stable({leap, yr, mon, day}));
endmodule

bind calendar_clock calendar_clock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .t_busy(t_busy), .d_busy(d_busy), .t_commit(t_commit), .d_commit(d_commit),
  .sec(sec), .min(min), .hr(hr), .day(day), .mon(mon), .yr(yr), .leap(leap)
);

// File: tb/calendar_clock_test.sv
`timescale 1ns/1ps
module calendar_clock_test;
  localparam int COMMIT = 2;
  localparam int NV = 12;
  // {time in, date in, time after one tick, date after one tick}
  localparam logic [127:0] VEC [NV] = '{
    {32'h00000000, 32'h00000101, 32'h00000001, 32'h00000101},
    {32'h0000003B, 32'h00000101, 32'h00000100, 32'h00000101},
    {32'h00003B3B, 32'h00000101, 32'h00010000, 32'h00000101},
    {32'h00173B3B, 32'h0005030F, 32'h00000000, 32'h00050310},
    {32'h00173B3B, 32'h0000011F, 32'h00000000, 32'h00000201},
    {32'h00173B3B, 32'h0001021C, 32'h00000000, 32'h00010301},
    {32'h00173B3B, 32'h0042021C, 32'h00000000, 32'h0042021D},
    {32'h00173B3B, 32'h0042021D, 32'h00000000, 32'h00420301},
    {32'h00173B3B, 32'h0003041E, 32'h00000000, 32'h00030501},
    {32'h00173B3B, 32'h00040B1E, 32'h00000000, 32'h00040C01},
    {32'h00173B3B, 32'h000C0C1F, 32'h00000000, 32'h000D0101},
    {32'h00173B3B, 32'h003F0C1F, 32'h00000000, 32'h00000101}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int n_run = 0;
  int n_fail = 0;
  logic [31:0] v;

  calendar_clock #(.COMMIT_CYCLES(COMMIT)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int k = 0; k < 16; k++) begin
      rd(2'd0, c);
      if (c == 32'd0) break;
      @(negedge clk);
    end
  endtask

  function automatic string vec_req(input int i);
    case (i)
      0, 1, 2:   vec_req = "R7";
      3, 4, 8, 9: vec_req = "R8";
      5, 6, 7:   vec_req = "R9";
      default:   vec_req = "R10";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, v); check("R1 ctrl", v, 32'h0);
    rd(2'd1, v); check("R1 time", v, 32'h0);
    rd(2'd2, v); check("R1 date", v, 32'h00000101);

    // R4: busy window length and delayed application
    wr(2'd1, 32'h00010203);
    rd(2'd0, v); check("R4 busy set", v, 32'h100);
    rd(2'd1, v); check("R4 old value kept", v, 32'h0);
    @(negedge clk);
    rd(2'd0, v); check("R4 busy second cycle", v, 32'h100);
    @(negedge clk);
    rd(2'd0, v); check("R4 busy cleared", v, 32'h0);
    rd(2'd1, v); check("R4 committed", v, 32'h00010203);

    // R5
    wr(2'd2, 32'h0005030F);
    rd(2'd0, v); check("R5 busy set", v, 32'h80);
    rd(2'd2, v); check("R5 old value kept", v, 32'h00000101);
    @(negedge clk);
    rd(2'd0, v); check("R5 busy second cycle", v, 32'h80);
    @(negedge clk);
    rd(2'd0, v); check("R5 busy cleared", v, 32'h0);
    rd(2'd2, v); check("R5 committed", v, 32'h0005030F);

    // R6: second write during busy dropped
    wr(2'd1, 32'h00020304);
    wr(2'd1, 32'h00111111);
    wait_idle();
    rd(2'd1, v); check("R6 time write during busy", v, 32'h00020304);
    wr(2'd2, 32'h00020304);
    wr(2'd2, 32'h00010B11);
    wait_idle();
    rd(2'd2, v); check("R6 date write during busy", v, 32'h00020304);

    // R2 / R3: unused bits masked
    wr(2'd1, 32'hFFE5C6C7);
    wr(2'd2, 32'hFF83F4EA);
    wait_idle();
    rd(2'd1, v); check("R2 time mask", v, 32'h00050607);
    rd(2'd2, v); check("R3 date mask", v, 32'h0003040A);

    // Vector walk: program, read back, one tick, compare both words
    for (int i = 0; i < NV; i++) begin
      wr(2'd1, VEC[i][127:96]);
      wr(2'd2, VEC[i][95:64]);
      wait_idle();
      rd(2'd1, v); check("R2 readback", v, VEC[i][127:96]);
      rd(2'd2, v); check("R3 readback", v, VEC[i][95:64]);
      pulse_tick();
      rd(2'd1, v); check({vec_req(i), " time after tick"}, v, VEC[i][63:32]);
      rd(2'd2, v); check({vec_req(i), " R11 date same edge"}, v, VEC[i][31:0]);
    end

    // R11: nothing moves without tick or commit
    repeat (5) @(negedge clk);
    rd(2'd1, v); check("R11 time hold", v, 32'h0);
    rd(2'd2, v); check("R11 date hold", v, 32'h00000101);

    // R12: commit wins over a coincident tick
    wr(2'd1, 32'h00173B3B);
    wr(2'd2, 32'h0000011F);
    wait_idle();
    wr(2'd1, 32'h00000505);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    rd(2'd1, v); check("R12 commit beats tick", v, 32'h00000505);
    rd(2'd2, v); check("R12 no carry", v, 32'h0000011F);
    pulse_tick();
    rd(2'd1, v); check("R12 counting resumes", v, 32'h00000506);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule